// File: doc/BRIEF.md
# ECC Fault Injection and Error Capture Unit

This unit sits beside the ECC encoder and checker of a 64-bit memory data path that carries 8 check bits per beat. On the write side it can flip chosen data bits and check bits before they reach memory, so that software can provoke correctable and uncorrectable errors on purpose. On the read side it takes one error indication per beat from the checker, keeps a sticky flag for each error class, and records the first reported failure: its data word, received check byte, address and class.

Correctable (single-bit) errors are counted against a programmable threshold, so a noisy location does not flood the interrupt line. Software reaches every setting and every captured field through a small word-addressed register port with a combinational read. Each error class can be kept out of detection entirely, and each has its own interrupt enable.

Top module: `ecc_err_mgr`

## Requirements
- R1: When bit 8 of the injection control word (register 2) is set, write data out equals write data in XOR {mask high (register 0), mask low (register 1)}. When bit 8 is clear, write data passes through unchanged.
- R2: When injection is enabled, the outgoing check byte equals the incoming check byte XOR bits 7:0 of register 2. Otherwise the check byte passes through unchanged.
- R3: Registers 0 and 1 (32 bits) and register 2 (bits 8:0) read back the last value written to them.
- R4: Register 3 holds the sticky correctable flag in bit 0 and the uncorrectable flag in bit 1. Writing a 1 to a bit clears that flag, and writing a 0 leaves it unchanged.
- R5: A reported error captures the beat into read-only registers: data 63:32 at 7, data 31:0 at 8, check byte in bits 7:0 of 9, address 31:0 at 10, and the upper address bits zero-extended at 11.
- R6: Captured fields stay frozen while any flag in register 3 is set. The next capture happens only after both flags have been cleared.
- R7: Register 6 bits 23:16 hold the correctable-error threshold, and bits 7:0 read the current count. The correctable flag is set by the error that brings the count to the threshold. A threshold of 0 or 1 reports every error.
- R8: The correctable counter returns to 0 when it reaches the threshold, and also when software clears flag bit 0.
- R9: Register 5 bit 0 enables the interrupt for the correctable flag and bit 1 enables it for the uncorrectable flag. irq is the OR of the enabled flags that are set.
- R10: Register 4 bit 0 suppresses detection of correctable errors and bit 1 suppresses uncorrectable ones. A suppressed beat sets no flag, changes no count and captures nothing.
- R11: When one beat signals both classes, both flags are set and the capture records the uncorrectable class: register 9 bit 8 is 1 for an uncorrectable capture and 0 for a correctable one.
- R12: After reset every register reads 0, irq is low and write data passes through unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wr_data_in | input | DATA_W | Write data from the encoder |
| wr_chk_in | input | CHK_W | Check byte from the encoder |
| wr_data_out | output | DATA_W | Write data toward memory |
| wr_chk_out | output | CHK_W | Check byte toward memory |
| rd_valid | input | 1 | Read beat qualifier |
| rd_sbe | input | 1 | Checker saw a correctable error |
| rd_mbe | input | 1 | Checker saw an uncorrectable error |
| rd_data | input | DATA_W | Read data of the beat |
| rd_chk | input | CHK_W | Received check byte of the beat |
| rd_addr | input | MADDR_W | Memory address of the beat |
| irq | output | 1 | Error interrupt |

## Verification
The properties assume that the error indications are only meaningful while rd_valid is high, and that all inputs are settled at every rising edge. The stimulus meets both conditions because it changes inputs only on the falling edge and holds the error bits low outside a beat. The properties also assume that a flag is never cleared in the same cycle that a new error of that class arrives, since in that case the set wins. The stimulus keeps register writes and error beats in separate cycles.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

    localparam int REG_W       = 32;
    localparam int INJ_EN_BIT  = 8;
    localparam int THR_LSB     = 16;
    localparam int THR_W       = 8;
    localparam int CAP_KIND_BIT = 8;

    localparam int A_INJ_HI   = 0;
    localparam int A_INJ_LO   = 1;
    localparam int A_INJ_CTL  = 2;
    localparam int A_STATUS   = 3;
    localparam int A_DISABLE  = 4;
    localparam int A_IRQ_EN   = 5;
    localparam int A_SBE_MGMT = 6;
    localparam int A_CAP_HI   = 7;
    localparam int A_CAP_LO   = 8;
    localparam int A_CAP_ATTR = 9;
    localparam int A_CAP_ADDR = 10;
    localparam int A_CAP_EXT  = 11;

    // bit 0: correctable, bit 1: uncorrectable
    typedef struct packed {
        logic mbe;
        logic sbe;
    } err_class_t;

    function automatic logic [REG_W-1:0] mgmt_word(input logic [THR_W-1:0] thr,
                                                   input logic [THR_W-1:0] cnt);
        logic [REG_W-1:0] w;
        w = '0;
        w[THR_LSB +: THR_W] = thr;
        w[THR_W-1:0]        = cnt;
        return w;
    endfunction

endpackage

// File: rtl/ecc_inject.sv
module ecc_inject #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8
) (
    input  logic              en,
    input  logic [DATA_W-1:0] mask_data,
    input  logic [CHK_W-1:0]  mask_chk,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  chk_in,
    output logic [DATA_W-1:0] data_out,
    output logic [CHK_W-1:0]  chk_out
);
    always_comb begin
        data_out = data_in;
        chk_out  = chk_in;
        if (en) begin
            data_out = data_in ^ mask_data;
            chk_out  = chk_in ^ mask_chk;
        end
    end
endmodule

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             clr,
    input  logic [CNT_W-1:0] thr,
    output logic             report,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W:0] nxt;

    always_comb begin
        nxt    = {1'b0, count} + 1'b1;
        report = hit && (nxt >= {1'b0, thr});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (hit) begin
            count <= report ? '0 : nxt[CNT_W-1:0];
        end else if (clr) begin
            count <= '0;
        end
    end
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
    parameter int DATA_W  = 64,
    parameter int CHK_W   = 8,
    parameter int MADDR_W = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic               kind_mbe,
    input  logic [DATA_W-1:0]  data,
    input  logic [CHK_W-1:0]   chk,
    input  logic [MADDR_W-1:0] addr,
    output logic [DATA_W-1:0]  cap_data,
    output logic [CHK_W-1:0]   cap_chk,
    output logic [MADDR_W-1:0] cap_addr,
    output logic               cap_mbe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_data <= '0;
            cap_chk  <= '0;
            cap_addr <= '0;
            cap_mbe  <= 1'b0;
        end else if (take) begin
            cap_data <= data;
            cap_chk  <= chk;
            cap_addr <= addr;
            cap_mbe  <= kind_mbe;
        end
    end
endmodule

// File: rtl/ecc_err_mgr.sv
module ecc_err_mgr
    import ecc_err_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int CHK_W   = 8,
    parameter int MADDR_W = 40,
    parameter int REG_AW  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [DATA_W-1:0]  wr_data_in,
    input  logic [CHK_W-1:0]   wr_chk_in,
    output logic [DATA_W-1:0]  wr_data_out,
    output logic [CHK_W-1:0]   wr_chk_out,
    input  logic               rd_valid,
    input  logic               rd_sbe,
    input  logic               rd_mbe,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic [CHK_W-1:0]   rd_chk,
    input  logic [MADDR_W-1:0] rd_addr,
    output logic               irq
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = MADDR_W - 32;

    logic [HALF_W-1:0] inj_hi_q, inj_lo_q;
    logic [CHK_W-1:0]  inj_chk_q;
    logic              inj_en_q;
    err_class_t        sts_q, dis_q, ien_q;
    logic [THR_W-1:0]  thr_q;
    logic [THR_W-1:0]  sbe_cnt;

    logic [DATA_W-1:0]  cap_data;
    logic [CHK_W-1:0]   cap_chk;
    logic [MADDR_W-1:0] cap_addr;
    logic               cap_mbe;

    logic       wr_sel_hi, wr_sel_lo, wr_sel_ctl, wr_sel_sts;
    logic       wr_sel_dis, wr_sel_ien, wr_sel_mgmt;
    logic       sbe_hit, mbe_hit, sbe_report, sbe_clr, cap_take;
    err_class_t sts_d;

    ecc_inject #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_inject (
        .en        (inj_en_q),
        .mask_data ({inj_hi_q, inj_lo_q}),
        .mask_chk  (inj_chk_q),
        .data_in   (wr_data_in),
        .chk_in    (wr_chk_in),
        .data_out  (wr_data_out),
        .chk_out   (wr_chk_out)
    );

    always_comb begin
        wr_sel_hi   = reg_we && (reg_addr == REG_AW'(A_INJ_HI));
        wr_sel_lo   = reg_we && (reg_addr == REG_AW'(A_INJ_LO));
        wr_sel_ctl  = reg_we && (reg_addr == REG_AW'(A_INJ_CTL));
        wr_sel_sts  = reg_we && (reg_addr == REG_AW'(A_STATUS));
        wr_sel_dis  = reg_we && (reg_addr == REG_AW'(A_DISABLE));
        wr_sel_ien  = reg_we && (reg_addr == REG_AW'(A_IRQ_EN));
        wr_sel_mgmt = reg_we && (reg_addr == REG_AW'(A_SBE_MGMT));
    end

    // error classification of the incoming beat
    always_comb begin
        sbe_hit  = rd_valid && rd_sbe && !dis_q.sbe;
        mbe_hit  = rd_valid && rd_mbe && !dis_q.mbe;
        sbe_clr  = wr_sel_sts && reg_wdata[0];
        cap_take = (sbe_report || mbe_hit) && !(sts_q.sbe || sts_q.mbe);
        sts_d.sbe = sbe_report || (sts_q.sbe && !(wr_sel_sts && reg_wdata[0]));
        sts_d.mbe = mbe_hit    || (sts_q.mbe && !(wr_sel_sts && reg_wdata[1]));
    end

    ecc_sbe_counter #(.CNT_W(THR_W)) u_sbe_cnt (
        .clk    (clk),
        .rst    (rst),
        .hit    (sbe_hit),
        .clr    (sbe_clr),
        .thr    (thr_q),
        .report (sbe_report),
        .count  (sbe_cnt)
    );

    ecc_capture #(.DATA_W(DATA_W), .CHK_W(CHK_W), .MADDR_W(MADDR_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .take     (cap_take),
        .kind_mbe (mbe_hit),
        .data     (rd_data),
        .chk      (rd_chk),
        .addr     (rd_addr),
        .cap_data (cap_data),
        .cap_chk  (cap_chk),
        .cap_addr (cap_addr),
        .cap_mbe  (cap_mbe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            inj_hi_q  <= '0;
            inj_lo_q  <= '0;
            inj_chk_q <= '0;
            inj_en_q  <= 1'b0;
            sts_q     <= '0;
            dis_q     <= '0;
            ien_q     <= '0;
            thr_q     <= '0;
        end else begin
            sts_q <= sts_d;
            if (wr_sel_hi)   inj_hi_q <= reg_wdata[HALF_W-1:0];
            if (wr_sel_lo)   inj_lo_q <= reg_wdata[HALF_W-1:0];
            if (wr_sel_ctl) begin
                inj_chk_q <= reg_wdata[CHK_W-1:0];
                inj_en_q  <= reg_wdata[INJ_EN_BIT];
            end
            if (wr_sel_dis)  dis_q <= reg_wdata[1:0];
            if (wr_sel_ien)  ien_q <= reg_wdata[1:0];
            if (wr_sel_mgmt) thr_q <= reg_wdata[THR_LSB +: THR_W];
        end
    end

    assign irq = (sts_q.sbe && ien_q.sbe) || (sts_q.mbe && ien_q.mbe);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(A_INJ_HI):   reg_rdata = 32'(inj_hi_q);
            REG_AW'(A_INJ_LO):   reg_rdata = 32'(inj_lo_q);
            REG_AW'(A_INJ_CTL): begin
                reg_rdata[CHK_W-1:0]  = inj_chk_q;
                reg_rdata[INJ_EN_BIT] = inj_en_q;
            end
            REG_AW'(A_STATUS):   reg_rdata = 32'(sts_q);
            REG_AW'(A_DISABLE):  reg_rdata = 32'(dis_q);
            REG_AW'(A_IRQ_EN):   reg_rdata = 32'(ien_q);
            REG_AW'(A_SBE_MGMT): reg_rdata = mgmt_word(thr_q, sbe_cnt);
            REG_AW'(A_CAP_HI):   reg_rdata = 32'(cap_data[DATA_W-1:HALF_W]);
            REG_AW'(A_CAP_LO):   reg_rdata = 32'(cap_data[HALF_W-1:0]);
            REG_AW'(A_CAP_ATTR): begin
                reg_rdata[CHK_W-1:0]    = cap_chk;
                reg_rdata[CAP_KIND_BIT] = cap_mbe;
            end
            REG_AW'(A_CAP_ADDR): reg_rdata = cap_addr[31:0];
            REG_AW'(A_CAP_EXT):  reg_rdata = 32'(cap_addr[MADDR_W-1:32]);
            default:             reg_rdata = '0;
        endcase
    end

    localparam int EXT_CHECK = (EXT_W > 0 && EXT_W <= 32) ? 1 : 0;
    initial begin
        if (EXT_CHECK == 0) $error("MADDR_W must be between 33 and 64");
    end

endmodule

// File: rtl/ecc_err_chk.sv
module ecc_err_chk #(
    parameter int DATA_W = 64,
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              inj_en,
    input logic [DATA_W-1:0] wr_data_in,
    input logic [DATA_W-1:0] wr_data_out,
    input logic              rd_valid,
    input logic              rd_mbe,
    input logic              dis_mbe,
    input logic [1:0]        sts,
    input logic [DATA_W-1:0] cap_data,
    input logic              irq
);
    // R1
    inj_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        !inj_en |-> (wr_data_out == wr_data_in));

    // R4
    sbe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sts[0]) |-> $past(reg_we && reg_addr == REG_AW'(3) && reg_wdata[0]));

    // R4
    mbe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sts[1]) |-> $past(reg_we && reg_addr == REG_AW'(3) && reg_wdata[1]));

    // R6
    cap_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (sts != 2'b00) |=> $stable(cap_data));

    // R10
    mbe_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_mbe && dis_mbe && !sts[1]) |=> !sts[1]);

    // R12
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sts == 2'b00 && !irq));
endmodule

bind ecc_err_mgr ecc_err_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_err_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .inj_en      (inj_en_q),
    .wr_data_in  (wr_data_in),
    .wr_data_out (wr_data_out),
    .rd_valid    (rd_valid),
    .rd_mbe      (rd_mbe),
    .dis_mbe     (dis_q.mbe),
    .sts         (sts_q),
    .cap_data    (cap_data),
    .irq         (irq)
);

// File: tb/tb_ecc_err_mgr.sv
module tb_ecc_err_mgr;
    localparam int DATA_W = 64, CHK_W = 8, MADDR_W = 40, REG_AW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_we = 0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [DATA_W-1:0] wr_data_in = '0, wr_data_out, rd_data = '0;
    logic [CHK_W-1:0] wr_chk_in = '0, wr_chk_out, rd_chk = '0;
    logic rd_valid = 0, rd_sbe = 0, rd_mbe = 0, irq;
    logic [MADDR_W-1:0] rd_addr = '0;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ecc_err_mgr #(.DATA_W(DATA_W), .CHK_W(CHK_W), .MADDR_W(MADDR_W), .REG_AW(REG_AW)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wr_data_in(wr_data_in), .wr_chk_in(wr_chk_in),
        .wr_data_out(wr_data_out), .wr_chk_out(wr_chk_out),
        .rd_valid(rd_valid), .rd_sbe(rd_sbe), .rd_mbe(rd_mbe),
        .rd_data(rd_data), .rd_chk(rd_chk), .rd_addr(rd_addr), .irq(irq)
    );

    localparam logic [31:0] T_HI  [4] = '{32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    localparam logic [31:0] T_LO  [4] = '{32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'h9ABC_DEF0};
    localparam logic [31:0] T_CTL [4] = '{32'h0000_00FF, 32'h0000_01A5, 32'h0000_0100, 32'h0000_01FF};
    localparam logic [63:0] T_DIN [4] = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
                                          64'h0F0F_0F0F_F0F0_F0F0, 64'h0000_0000_0000_0000};
    localparam logic [7:0]  T_CIN [4] = '{8'h3C, 8'h00, 8'hA5, 8'h81};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = REG_AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = REG_AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic beat(input logic s, input logic m, input logic [63:0] d,
                        input logic [7:0] c, input logic [39:0] a);
        @(negedge clk);
        rd_valid = 1; rd_sbe = s; rd_mbe = m; rd_data = d; rd_chk = c; rd_addr = a;
        @(negedge clk);
        rd_valid = 0; rd_sbe = 0; rd_mbe = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;

        // R12: reset state
        for (int a = 0; a < 12; a++) begin
            rd(a, v);
            check("R12 reg reset", 64'(v), 64'h0);
        end
        check("R12 irq reset", 64'(irq), 64'h0);
        wr_data_in = 64'hDEAD_BEEF_0000_1111; wr_chk_in = 8'h5A;
        #1 check("R12 passthrough", wr_data_out, 64'hDEAD_BEEF_0000_1111);

        // R1 R2 R3: injection vector table
        for (int i = 0; i < 4; i++) begin
            logic [63:0] ed;
            logic [7:0]  ec;
            wr(0, T_HI[i]); wr(1, T_LO[i]); wr(2, T_CTL[i]);
            rd(0, v); check("R3 mask hi readback", 64'(v), 64'(T_HI[i]));
            rd(1, v); check("R3 mask lo readback", 64'(v), 64'(T_LO[i]));
            rd(2, v); check("R3 ctl readback", 64'(v), 64'(T_CTL[i]));
            wr_data_in = T_DIN[i]; wr_chk_in = T_CIN[i];
            ed = T_CTL[i][8] ? (T_DIN[i] ^ {T_HI[i], T_LO[i]}) : T_DIN[i];
            ec = T_CTL[i][8] ? (T_CIN[i] ^ T_CTL[i][7:0]) : T_CIN[i];
            #1;
            check("R1 data inject", wr_data_out, ed);
            check("R2 check inject", 64'(wr_chk_out), 64'(ec));
        end
        wr(2, 32'h0);

        // R4 R5 R9: uncorrectable capture with interrupt
        wr(5, 32'h2);
        beat(0, 1, 64'hAAAA_BBBB_CCCC_DDDD, 8'h77, 40'hAB_1234_5678);
        rd(3, v); check("R4 mbe flag", 64'(v), 64'h2);
        check("R9 irq mbe enabled", 64'(irq), 64'h1);
        rd(7, v); check("R5 cap hi", 64'(v), 64'hAAAA_BBBB);
        rd(8, v); check("R5 cap lo", 64'(v), 64'hCCCC_DDDD);
        rd(9, v); check("R5 cap attr chk+mbe", 64'(v), 64'h177);
        rd(10, v); check("R5 cap addr", 64'(v), 64'h1234_5678);
        rd(11, v); check("R5 cap ext", 64'(v), 64'hAB);

        // R6: frozen while flag set
        beat(0, 1, 64'h1111_2222_3333_4444, 8'h11, 40'h00_0000_0040);
        rd(8, v); check("R6 capture frozen", 64'(v), 64'hCCCC_DDDD);
        wr(3, 32'h1);
        rd(3, v); check("R4 writing other bit keeps mbe", 64'(v), 64'h2);
        wr(3, 32'h2);
        rd(3, v); check("R4 w1c mbe", 64'(v), 64'h0);
        check("R9 irq drops", 64'(irq), 64'h0);

        // R7 threshold 0 reports every; R6 recapture; R9 sbe not enabled
        beat(1, 0, 64'h0000_0001_0000_0002, 8'h03, 40'h01_0000_0100);
        rd(3, v); check("R7 thr0 every error", 64'(v), 64'h1);
        rd(8, v); check("R6 recapture after clear", 64'(v), 64'h2);
        rd(9, v); check("R11 sbe capture kind 0", 64'(v), 64'h003);
        check("R9 sbe not enabled", 64'(irq), 64'h0);
        wr(3, 32'h1);

        // R7 R8: threshold 3
        wr(6, 32'h0003_0000);
        beat(1, 0, 64'h5, 8'h0, 40'h0);
        beat(1, 0, 64'h6, 8'h0, 40'h0);
        rd(3, v); check("R7 below threshold", 64'(v), 64'h0);
        rd(6, v); check("R7 count readback", 64'(v), 64'h0003_0002);
        beat(1, 0, 64'h7, 8'h0, 40'h0);
        rd(3, v); check("R7 flag at threshold", 64'(v), 64'h1);
        rd(6, v); check("R8 count reset at threshold", 64'(v), 64'h0003_0000);
        rd(8, v); check("R7 capture reporting beat", 64'(v), 64'h7);
        wr(3, 32'h1);
        beat(1, 0, 64'h8, 8'h0, 40'h0);
        beat(1, 0, 64'h9, 8'h0, 40'h0);
        wr(3, 32'h1);
        rd(6, v); check("R8 count reset on clear", 64'(v), 64'h0003_0000);
        wr(6, 32'h0001_0000);

        // R10: per-class disable
        wr(4, 32'h2);
        beat(0, 1, 64'hF0, 8'h0, 40'h0);
        rd(3, v); check("R10 mbe suppressed", 64'(v), 64'h0);
        rd(8, v); check("R10 no capture when suppressed", 64'(v), 64'h7);
        beat(1, 0, 64'hF1, 8'h0, 40'h0);
        rd(3, v); check("R10 sbe still detected", 64'(v), 64'h1);
        wr(3, 32'h3);
        wr(4, 32'h1);
        beat(1, 0, 64'hF2, 8'h0, 40'h0);
        rd(3, v); check("R10 sbe suppressed", 64'(v), 64'h0);
        rd(6, v); check("R10 count untouched", 64'(v), 64'h0001_0000);
        wr(4, 32'h0);

        // R11: both classes in one beat
        wr(5, 32'h1);
        beat(1, 1, 64'hBEEF, 8'h42, 40'h00_0000_0080);
        rd(3, v); check("R11 both flags", 64'(v), 64'h3);
        rd(9, v); check("R11 mbe capture priority", 64'(v), 64'h142);
        check("R9 irq sbe enabled", 64'(irq), 64'h1);
        wr(3, 32'h1);
        check("R9 mbe not enabled", 64'(irq), 64'h0);
        wr(3, 32'h2);

        done = 1;
        summary();
    end
endmodule